// File: doc/BRIEF.md
# Address-Inclusive SECDED Guard for a 32-bit SRAM

This block sits between a single-port SRAM and its users. It adds single-error-correct, double-error-detect protection to each 32-bit word. On the write side a combinational encoder turns the word and its word address into a 7-bit check field, which the SRAM stores next to the data. On the read side the block takes the returned word, the returned check field and the address that was requested. It recomputes the check field over that word and that address, and XORs the two to form a syndrome.

A single flipped data bit is repaired and reported as a corrected error. A flipped check bit is reported as a corrected error and the data is left untouched. Every other nonzero syndrome is reported as uncorrectable, and the word is passed on unmodified. The address is part of the code. If a faulty row decoder returns a word stored at a different address, the syndrome is nonzero and the fault shows up as an error.

Reads enter and leave through a valid/ready stream with one register stage. A read is accepted on a cycle where `rd_valid` and `rd_ready` are both high. `rd_ready` is high when the output register is empty or is being drained that cycle (`dout_valid` low or `dout_ready` high). While `dout_valid` is high and `dout_ready` is low, the output word and its flags are held. The two status pulses travel in the same register as the word they describe.

Top module: `sram_ecc_guard`

## Requirements
- R1: `wr_check` equals the XOR of the column codes of every set bit of the vector {address, data}. Data bit i uses column i and address bit j uses column 32+j. Column k is the k-th smallest 7-bit value whose bit count is odd and at least 3. Stored check bit r has the unit column with only bit r set.
- R2: A read whose data, check field and address agree with the encoding gives `dout_data` equal to the read data, with `dout_sec` and `dout_ded` both 0.
- R3: A read with exactly one data bit inverted gives the original data word, with `dout_sec`=1 and `dout_ded`=0.
- R4: A read with exactly one check bit inverted gives the read data unchanged, with `dout_sec`=1 and `dout_ded`=0.
- R5: A read with two bits inverted, in any mix of data and check positions, gives `dout_ded`=1 and `dout_sec`=0, and `dout_data` equal to the raw read data.
- R6: A read whose requested address differs in one or two bits from the address used at write time, with the data and check field intact, gives `dout_ded`=1 and `dout_sec`=0, with the data passed through.
- R7: A syndrome of odd weight that matches no data column and no check column (for example all seven check bits inverted, syndrome 7'h7F) gives `dout_ded`=1 with the data passed through.
- R8: After reset `dout_valid`, `dout_sec`, `dout_ded` and `dout_data` are 0 and `rd_ready` is 1.
- R9: An accepted read appears on the outputs on the next clock edge. While `dout_valid`=1 and `dout_ready`=0, `rd_ready` is 0 and the output word and flags do not change.
- R10: Whenever `dout_valid` is 0, `dout_sec` and `dout_ded` are 0. The flags never both read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 32 | Word about to be written to the SRAM |
| wr_addr | input | ADDR_W | Word address of that write |
| wr_check | output | 7 | Check field to store beside the word |
| rd_valid | input | 1 | Read response from the SRAM is present |
| rd_ready | output | 1 | Guard can take the read response |
| rd_addr | input | ADDR_W | Word address that was requested |
| rd_data | input | 32 | Word returned by the SRAM |
| rd_check | input | 7 | Check field returned by the SRAM |
| dout_valid | output | 1 | Checked word is present |
| dout_ready | input | 1 | Consumer takes the checked word |
| dout_data | output | 32 | Corrected or passed-through word |
| dout_sec | output | 1 | Single error was corrected in this word |
| dout_ded | output | 1 | Uncorrectable error in this word |

## Verification
The bench builds the guard with ADDR_W set to 24, one below the largest width the column pool allows. This uses every weight-3 and weight-5 code as a data or address column, so address bits high in the column list can be inverted directly. With that width, 7'h7F is the only odd syndrome that matches no column, which is exactly what R7 needs. At the default width of 15 address bits, several odd syndromes match no column at all.

// File: rtl/sram_ecc_pkg.sv
package sram_ecc_pkg;
  localparam int DATA_W     = 32;
  localparam int CHK_W      = 7;
  localparam int CODE_SPACE = 1 << CHK_W;
  // data plus address columns that the odd, weight>=3 pool can serve
  localparam int MAX_ADDR_W = 57 - DATA_W;

  function automatic int bit_count(input int v);
    int n;
    n = 0;
    for (int b = 0; b < CHK_W; b++) n += (v >> b) & 1;
    return n;
  endfunction

  // k-th smallest code of odd weight and weight at least 3
  function automatic logic [CHK_W-1:0] column_code(input int idx);
    int k;
    int w;
    logic [CHK_W-1:0] r;
    k = 0;
    r = '0;
    for (int v = 0; v < CODE_SPACE; v++) begin
      w = bit_count(v);
      if ((w % 2 == 1) && (w > 1)) begin
        if (k == idx) r = v[CHK_W-1:0];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sram_ecc_enc.sv
module sram_ecc_enc
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] addr,
  output logic [CHK_W-1:0]  check
);
  localparam int NCOL = DATA_W + ADDR_W;

  logic [NCOL-1:0]  covered;
  logic [CHK_W-1:0] term [NCOL];

  assign covered = {addr, data};

  for (genvar g = 0; g < NCOL; g++) begin : g_col
    localparam logic [CHK_W-1:0] CODE = column_code(g);
    assign term[g] = covered[g] ? CODE : '0;
  end

  always_comb begin
    check = '0;
    for (int i = 0; i < NCOL; i++) check ^= term[i];
  end
endmodule

// File: rtl/sram_ecc_dec.sv
module sram_ecc_dec
  import sram_ecc_pkg::*;
(
  input  logic [CHK_W-1:0]  syndrome,
  input  logic [DATA_W-1:0] data_raw,
  output logic [DATA_W-1:0] data_fix,
  output logic              sec,
  output logic              ded
);
  logic [DATA_W-1:0] flip;
  logic              check_hit;

  // only a data column flips a bit; address columns fall to ded
  for (genvar g = 0; g < DATA_W; g++) begin : g_match
    localparam logic [CHK_W-1:0] CODE = column_code(g);
    assign flip[g] = (syndrome == CODE);
  end

  assign check_hit = $onehot(syndrome);
  assign sec       = (|flip) || check_hit;
  assign ded       = (syndrome != '0) && !sec;
  assign data_fix  = data_raw ^ flip;
endmodule

// File: rtl/sram_ecc_slice.sv
module sram_ecc_slice #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_payload <= '0;
    end else if (in_ready) begin
      out_valid   <= in_valid;
      out_payload <= in_valid ? in_payload : '0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));
endmodule

// File: rtl/sram_ecc_guard.sv
module sram_ecc_guard
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [CHK_W-1:0]  wr_check,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_check,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [DATA_W-1:0] dout_data,
  output logic              dout_sec,
  output logic              dout_ded
);
  localparam int PAY_W = DATA_W + 2;

  logic [CHK_W-1:0]  recomputed;
  logic [CHK_W-1:0]  syndrome;
  logic [DATA_W-1:0] fixed_data;
  logic              dec_sec;
  logic              dec_ded;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  sram_ecc_enc #(.ADDR_W(ADDR_W)) u_enc_wr (
    .data (wr_data),
    .addr (wr_addr),
    .check(wr_check)
  );

  sram_ecc_enc #(.ADDR_W(ADDR_W)) u_enc_rd (
    .data (rd_data),
    .addr (rd_addr),
    .check(recomputed)
  );

  assign syndrome = recomputed ^ rd_check;

  sram_ecc_dec u_dec (
    .syndrome(syndrome),
    .data_raw(rd_data),
    .data_fix(fixed_data),
    .sec     (dec_sec),
    .ded     (dec_ded)
  );

  assign pay_in = {dec_ded, dec_sec, fixed_data};

  sram_ecc_slice #(.W(PAY_W)) u_slice (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rd_valid),
    .in_ready   (rd_ready),
    .in_payload (pay_in),
    .out_valid  (dout_valid),
    .out_ready  (dout_ready),
    .out_payload(pay_out)
  );

  assign dout_data = pay_out[DATA_W-1:0];
  assign dout_sec  = pay_out[DATA_W];
  assign dout_ded  = pay_out[DATA_W+1];

  // R2
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && syndrome == '0) |=>
      (dout_valid && dout_data == $past(rd_data) && !dout_sec && !dout_ded));

  // R3
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && dec_sec) |=>
      ($countones(dout_data ^ $past(rd_data)) <= 1));

  // R5
  ded_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && dec_ded) |=> (dout_data == $past(rd_data)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (!dout_sec && !dout_ded));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_sec && dout_ded));
endmodule

// File: tb/sram_ecc_guard_test.sv
module sram_ecc_guard_test;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [6:0]    wr_check;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data = '0;
  logic [6:0]    rd_check = '0;
  logic          dout_valid;
  logic          dout_ready = 1'b1;
  logic [31:0]   dout_data;
  logic          dout_sec;
  logic          dout_ded;

  int n_checks = 0;
  int n_fails = 0;

  always #5 clk = ~clk;

  sram_ecc_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_data), .wr_addr(wr_addr), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_check(rd_check),
    .dout_valid(dout_valid), .dout_ready(dout_ready),
    .dout_data(dout_data), .dout_sec(dout_sec), .dout_ded(dout_ded)
  );

  function automatic logic [6:0] ref_col(input int idx);
    int seen;
    seen = 0;
    for (int v = 7; v < 128; v++) begin
      if ($countones(v[6:0]) % 2 == 1 && $countones(v[6:0]) >= 3) begin
        if (seen == idx) return v[6:0];
        seen++;
      end
    end
    return 7'h00;
  endfunction

  function automatic logic [6:0] ref_enc(input logic [31:0] d, input logic [AW-1:0] a);
    logic [6:0] acc;
    acc = '0;
    for (int i = 0; i < 32; i++) if (d[i]) acc ^= ref_col(i);
    for (int j = 0; j < AW; j++) if (a[j]) acc ^= ref_col(32 + j);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic [AW-1:0] a, input logic [6:0] c);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = d; rd_addr = a; rd_check = c; dout_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [31:0] d, input bit s, input bit e);
    check(dout_valid == 1'b1, req, "valid", 64'(dout_valid), 64'd1);
    check(dout_data == d, req, "data", 64'(dout_data), 64'(d));
    check(dout_sec == s && dout_ded == e, req, "sec/ded",
          64'({dout_sec, dout_ded}), 64'({s, e}));
  endtask

  task automatic t_reset;
    // R8
    check(!dout_valid && !dout_sec && !dout_ded && dout_data == '0, "R8", "outputs",
          64'({dout_valid, dout_sec, dout_ded, dout_data}), 64'd0);
    check(rd_ready == 1'b1, "R8", "rd_ready", 64'(rd_ready), 64'd1);
  endtask

  task automatic t_encode;
    logic [31:0] dv [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0000_0001};
    logic [AW-1:0] av [4] = '{24'h00_0000, 24'hFF_FFFF, 24'h12_3456, 24'h80_0000};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr_data = dv[i]; wr_addr = av[i];
      #1;
      check(wr_check == ref_enc(dv[i], av[i]), "R1", "wr_check",
            64'(wr_check), 64'(ref_enc(dv[i], av[i])));
    end
  endtask

  task automatic t_clean;
    // R2
    apply(32'hCAFE_F00D, 24'h00_0123, ref_enc(32'hCAFE_F00D, 24'h00_0123));
    expect_out("R2", 32'hCAFE_F00D, 1'b0, 1'b0);
    apply(32'h0000_0000, 24'h00_0000, 7'h00);
    expect_out("R2", 32'h0000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_single_data;
    int pos [3] = '{0, 13, 31};
    logic [31:0] d;
    logic [AW-1:0] a;
    d = 32'h1357_9BDF; a = 24'h5A_A5A5;
    for (int i = 0; i < 3; i++) begin
      // R3
      apply(d ^ (32'd1 << pos[i]), a, ref_enc(d, a));
      expect_out("R3", d, 1'b1, 1'b0);
    end
  endtask

  task automatic t_check_bit;
    logic [31:0] d;
    logic [AW-1:0] a;
    d = 32'hA5A5_0F0F; a = 24'h00_0F00;
    for (int b = 0; b < 7; b += 3) begin
      // R4
      apply(d, a, ref_enc(d, a) ^ (7'd1 << b));
      expect_out("R4", d, 1'b1, 1'b0);
    end
  endtask

  task automatic t_double;
    logic [31:0] d;
    logic [AW-1:0] a;
    d = 32'h0F1E_2D3C; a = 24'h33_0033;
    // R5 two data bits
    apply(d ^ 32'h8000_0002, a, ref_enc(d, a));
    expect_out("R5", d ^ 32'h8000_0002, 1'b0, 1'b1);
    // R5 one data bit and one check bit
    apply(d ^ 32'h0001_0000, a, ref_enc(d, a) ^ 7'h20);
    expect_out("R5", d ^ 32'h0001_0000, 1'b0, 1'b1);
  endtask

  task automatic t_addr_fault;
    logic [31:0] d;
    logic [AW-1:0] a;
    d = 32'h7654_3210; a = 24'h0A_BCDE;
    // R6 single address bit, low and high columns
    apply(d, a ^ 24'h00_0001, ref_enc(d, a));
    expect_out("R6", d, 1'b0, 1'b1);
    apply(d, a ^ 24'h80_0000, ref_enc(d, a));
    expect_out("R6", d, 1'b0, 1'b1);
    // R6 two address bits
    apply(d, a ^ 24'h00_0410, ref_enc(d, a));
    expect_out("R6", d, 1'b0, 1'b1);
  endtask

  task automatic t_unused_odd;
    logic [31:0] d;
    logic [AW-1:0] a;
    d = 32'h2468_ACE0; a = 24'h11_1111;
    // R7 syndrome 7'h7F
    apply(d, a, ref_enc(d, a) ^ 7'h7F);
    expect_out("R7", d, 1'b0, 1'b1);
  endtask

  task automatic t_stall;
    logic [31:0] da, db;
    da = 32'h1111_2222; db = 32'h3333_4444;
    @(negedge clk);
    dout_ready = 1'b0;
    rd_valid = 1'b1; rd_data = da; rd_addr = '0; rd_check = ref_enc(da, '0);
    @(negedge clk);
    rd_data = db; rd_check = ref_enc(db, '0);
    // R9
    check(rd_ready == 1'b0, "R9", "rd_ready while stalled", 64'(rd_ready), 64'd0);
    @(negedge clk);
    check(dout_valid && dout_data == da, "R9", "held word", 64'(dout_data), 64'(da));
    check(rd_ready == 1'b0, "R9", "rd_ready still low", 64'(rd_ready), 64'd0);
    dout_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    check(dout_valid && dout_data == db, "R9", "next word", 64'(dout_data), 64'(db));
    @(negedge clk);
    // R10
    check(!dout_valid && !dout_sec && !dout_ded, "R10", "idle flags",
          64'({dout_valid, dout_sec, dout_ded}), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_encode;
    t_clean;
    t_single_data;
    t_check_bit;
    t_double;
    t_addr_fault;
    t_unused_odd;
    t_stall;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule